// File: doc/BRIEF.md
# Synchronous Serial Bit Receiver with Zero Deletion

This block turns a single serial receive line into a stream of data bits for a bit-oriented link. Two line codings sit behind one mode input. In level coding the line state gives the bit value. In transition coding a change of level marks every bit boundary, and a further change in the middle of the period marks a zero. The block finds bit periods in one of two ways. In internal timing a 16-tick window advances on an oversampling tick and realigns to line edges that arrive near a boundary. In strobe timing an external sample strobe sets the timing, and a select input picks which strobe edge latches each bit.

Every recovered line bit then goes through a zero-deletion stage that works the same way in both codings. A zero that follows exactly five ones is removed. Six ones followed by a zero are reported as a flag. A run of seven ones is reported as an abort. In transition coding the block also raises a one-cycle pulse when an expected boundary transition is missing. Downstream logic gets each surviving bit with a valid strobe, plus single-cycle flag, abort and code-violation pulses.

Top module: `sdlc_rx_decoder`

## Requirements
- R1: While reset is held and in the first cycle after its release, bit_valid, flag_pulse, abort_pulse and cv_pulse are all low.
- R2: With nrz_mode=0 and strobe_mode=0, each 16-tick period yields one decoded bit. The bit is 1 when the level in the first half of the period equals the level in the second half, and 0 when the level changes at mid-period.
- R3: With nrz_mode=1 and strobe_mode=0, each 16-tick period yields one decoded bit, equal to the line level sampled at tick 8 of the period (high = 1, low = 0).
- R4: With nrz_mode=0 and strobe_mode=0, cv_pulse goes high for one cycle when the first-half level of a period equals the second-half level of the period before it. This pulse comes before that period's bit and never in the same cycle as bit_valid.
- R5: A decoded 0 that follows exactly five consecutive decoded 1s produces no bit_valid. Every other 0 outside flag or abort runs, and every 1, is delivered with bit_valid and bit_out equal to its value.
- R6: A decoded 0 that follows exactly six consecutive 1s produces flag_pulse for one cycle and no bit_valid.
- R7: The seventh consecutive decoded 1 produces abort_pulse in the same cycle as its bit_valid. Further 1s give no further abort_pulse. The 0 that ends such a run produces neither bit_valid nor flag_pulse.
- R8: With strobe_mode=1, one bit is taken from the line on each rising strobe edge when strobe_rise=1, or on each falling edge when strobe_rise=0. The line level is used as the bit whatever nrz_mode holds, and cv_pulse stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Oversampling tick, 16 per bit in internal timing |
| rx_line | input | 1 | Serial receive line |
| nrz_mode | input | 1 | 1 = level coding, 0 = transition coding |
| strobe_mode | input | 1 | 1 = bit timing from strobe_in |
| strobe_in | input | 1 | External sample strobe |
| strobe_rise | input | 1 | 1 = latch on rising strobe edge, 0 = falling |
| bit_out | output | 1 | Delivered bit value, valid with bit_valid |
| bit_valid | output | 1 | One-cycle strobe for bit_out |
| flag_pulse | output | 1 | Flag pattern seen |
| abort_pulse | output | 1 | Seventh consecutive one seen |
| cv_pulse | output | 1 | Missing boundary transition in transition coding |

## Verification
The assertions assume that rx_line and strobe_in are already synchronous to clk. They also assume that nrz_mode and strobe_mode only change while the block is in reset, so that a code-violation or bit pulse can always be traced to the mode in force. The bench therefore drives all inputs on the falling clock edge. It sets the modes only around a reset, holds each half-period of line level for exactly eight ticks aligned to the window, and keeps the strobe high or low for at least two cycles. The random line bits lean toward ones so that stuffed zeros, flags and aborts turn up often alongside the directed cases.

// File: rtl/sdlc_rx_decoder.sv
module sdlc_rx_decoder #(
  parameter int OVS      = 16,
  parameter int SYNC_WIN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic rx_line,
  input  logic nrz_mode,
  input  logic strobe_mode,
  input  logic strobe_in,
  input  logic strobe_rise,
  output logic bit_out,
  output logic bit_valid,
  output logic flag_pulse,
  output logic abort_pulse,
  output logic cv_pulse
);
  localparam int PW = $clog2(OVS);
  localparam logic [PW-1:0] PH_ONE = PW'(1);
  localparam logic [PW-1:0] PH_Q1  = PW'(OVS / 4);
  localparam logic [PW-1:0] PH_MID = PW'(OVS / 2);
  localparam logic [PW-1:0] PH_Q3  = PW'((3 * OVS) / 4);
  localparam logic [PW-1:0] PH_LO  = PW'(SYNC_WIN);
  localparam logic [PW-1:0] PH_HI  = PW'(OVS - SYNC_WIN);

  logic          ln, ln_t, st_q, st_d;
  logic [PW-1:0] ph;
  logic          fa, fb, have_fb;
  logic [2:0]    ones;

  wire edge_seen = ln ^ ln_t;
  wire near_bnd  = (ph >= PH_HI) || (ph <= PH_LO);
  wire int_tick  = !strobe_mode && tick_en;
  wire stb_evt   = strobe_mode && (strobe_rise ? (st_q & ~st_d) : (~st_q & st_d));
  wire nrz_evt   = int_tick && nrz_mode && (ph == PH_MID);
  wire fm_a      = int_tick && !nrz_mode && (ph == PH_Q1);
  wire fm_b      = int_tick && !nrz_mode && (ph == PH_Q3);
  wire raw_evt   = stb_evt | nrz_evt | fm_b;
  wire raw_bit   = fm_b ? (fa == ln) : ln;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ln          <= 1'b1;
      ln_t        <= 1'b1;
      st_q        <= 1'b0;
      st_d        <= 1'b0;
      ph          <= '0;
      fa          <= 1'b1;
      fb          <= 1'b1;
      have_fb     <= 1'b0;
      ones        <= 3'd0;
      bit_out     <= 1'b0;
      bit_valid   <= 1'b0;
      flag_pulse  <= 1'b0;
      abort_pulse <= 1'b0;
      cv_pulse    <= 1'b0;
    end else begin
      ln          <= rx_line;
      st_q        <= strobe_in;
      st_d        <= st_q;
      bit_valid   <= 1'b0;
      flag_pulse  <= 1'b0;
      abort_pulse <= 1'b0;
      cv_pulse    <= 1'b0;

      if (tick_en) begin
        ln_t <= ln;
        ph   <= (edge_seen && near_bnd) ? PH_ONE : ph + PH_ONE;
      end

      if (fm_a) begin
        fa       <= ln;
        cv_pulse <= have_fb && (ln == fb);
      end
      if (fm_b) begin
        fb      <= ln;
        have_fb <= 1'b1;
      end

      if (raw_evt) begin
        if (raw_bit) begin
          bit_valid   <= 1'b1;
          bit_out     <= 1'b1;
          abort_pulse <= (ones == 3'd6);
          ones        <= (ones == 3'd7) ? 3'd7 : ones + 3'd1;
        end else begin
          ones <= 3'd0;
          if (ones == 3'd6) begin
            flag_pulse <= 1'b1;
          end else if (ones < 3'd5) begin
            bit_valid <= 1'b1;
            bit_out   <= 1'b0;
          end
        end
      end
    end
  end

  // R6
  flag_no_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_pulse |-> !bit_valid && !abort_pulse);

  // R4
  cv_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cv_pulse |-> !bit_valid && !flag_pulse);

  // R7
  abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |=> !abort_pulse);

  // R7
  abort_on_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> bit_valid && bit_out);

  // R8
  strobe_no_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_mode && $past(strobe_mode) |-> !cv_pulse);

  // R2
  bit_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid && !strobe_mode |=> !bit_valid);
endmodule

// File: tb/sdlc_rx_decoder_bench.sv
module sdlc_rx_decoder_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, tick_en = 1'b1, rx_line = 1'b1, nrz_mode = 1'b1;
  logic strobe_mode = 1'b0, strobe_in = 1'b0, strobe_rise = 1'b1;
  logic bit_out, bit_valid, flag_pulse, abort_pulse, cv_pulse;

  sdlc_rx_decoder u_sdlc_rx_decoder (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rx_line(rx_line),
    .nrz_mode(nrz_mode), .strobe_mode(strobe_mode), .strobe_in(strobe_in),
    .strobe_rise(strobe_rise), .bit_out(bit_out), .bit_valid(bit_valid),
    .flag_pulse(flag_pulse), .abort_pulse(abort_pulse), .cv_pulse(cv_pulse));

  int n_chk = 0, n_bad = 0;
  bit rec = 1'b0;
  int got[$];
  int expq[$];
  bit h1[$];
  bit h2[$];
  bit cur;
  int ones_m;

  // event codes: 0/1 data bit, 2 flag, 3 abort, 4 code violation
  always @(negedge clk) if (rec) begin
    if (cv_pulse) got.push_back(4);
    if (flag_pulse) got.push_back(2);
    if (bit_valid) got.push_back(bit_out ? 1 : 0);
    if (abort_pulse) got.push_back(3);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic void destuff(input bit b);
    if (b) begin
      expq.push_back(1);
      if (ones_m == 6) expq.push_back(3);
      if (ones_m < 7) ones_m++;
    end else begin
      if (ones_m == 6) expq.push_back(2);
      else if (ones_m < 5) expq.push_back(0);
      ones_m = 0;
    end
  endfunction

  function automatic void put_nrz(input bit b);
    h1.push_back(b); h2.push_back(b);
  endfunction

  function automatic void put_fm0(input bit b, input bit skip_bnd);
    bit first;
    first = skip_bnd ? cur : ~cur;
    h1.push_back(first);
    h2.push_back(b ? first : ~first);
    cur = b ? first : ~first;
  endfunction

  task automatic do_reset(input bit nrz, input bit stb, input bit sel);
    rec = 1'b0;
    rst_n = 1'b0; rx_line = 1'b1; strobe_in = 1'b0;
    nrz_mode = nrz; strobe_mode = stb; strobe_rise = sel;
    repeat (3) @(negedge clk);
    // R1
    chk(!bit_valid && !flag_pulse && !abort_pulse && !cv_pulse, "R1 reset outputs",
        {bit_valid, flag_pulse, abort_pulse, cv_pulse}, 0);
    got.delete();
    rst_n = 1'b1;
    rec = 1'b1;
  endtask

  task automatic compare(input string tag);
    chk(got.size() == expq.size(), {tag, " event count"}, got.size(), expq.size());
    for (int i = 0; i < got.size() && i < expq.size(); i++)
      chk(got[i] == expq[i], tag, got[i], expq[i]);
  endtask

  task automatic run_line(input bit nrz, input string tag);
    do_reset(nrz, 1'b0, 1'b1);
    @(negedge clk);
    chk(!bit_valid && !flag_pulse && !abort_pulse && !cv_pulse, "R1 first cycle",
        {bit_valid, flag_pulse, abort_pulse, cv_pulse}, 0);
    repeat (14) @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < h1.size(); k++) begin
      rx_line = h1[k]; repeat (8) @(negedge clk);
      rx_line = h2[k]; repeat (8) @(negedge clk);
    end
    rec = 1'b0;
    h1.push_front(1'b1); h2.push_front(1'b1);
    expq.delete(); ones_m = 0;
    for (int k = 0; k < h1.size(); k++) begin
      if (nrz) destuff(h2[k]);
      else begin
        if (k > 0 && h1[k] == h2[k-1]) expq.push_back(4);
        destuff(h1[k] == h2[k]);
      end
    end
    compare(tag);
    h1.delete(); h2.delete(); cur = 1'b1;
  endtask

  task automatic run_strobe(input bit sel, input int nbits, input string tag);
    bit d, g;
    do_reset(1'b0, 1'b1, sel);
    expq.delete(); ones_m = 0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      d = ($urandom % 4) != 0;
      g = ($urandom % 4) != 0;
      destuff(sel ? d : g);
      rx_line = d; strobe_in = 1'b0; repeat (2) @(negedge clk);
      strobe_in = 1'b1; repeat (2) @(negedge clk);
      rx_line = g; @(negedge clk);
      strobe_in = 1'b0; repeat (2) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    rec = 1'b0;
    compare(tag);
  endtask

  task automatic seq_nrz(input string s);
    for (int i = 0; i < s.len(); i++) put_nrz(s[i] == "1");
  endtask

  task automatic seq_fm0(input string s);
    for (int i = 0; i < s.len(); i++) put_fm0(s[i] == "1", 1'b0);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    cur = 1'b1;
    // R3 plain level decode
    seq_nrz("0100110101"); run_line(1'b1, "R3 nrz directed");
    // R5 stuffed zero removed, other zeros kept
    seq_nrz("01111101011111001"); run_line(1'b1, "R5 nrz stuffing");
    // R6 flag
    seq_nrz("0011111100101111110"); run_line(1'b1, "R6 nrz flag");
    // R7 abort then terminating zero swallowed
    seq_nrz("0111111111011111110"); run_line(1'b1, "R7 nrz abort");
    // R2 transition coding decode
    seq_fm0("0100110101"); run_line(1'b0, "R2 fm0 directed");
    seq_fm0("01111101111111001111110"); run_line(1'b0, "R2 R5 R6 R7 fm0 patterns");
    // R4 missing boundary transitions
    put_fm0(1'b0, 1'b0); put_fm0(1'b1, 1'b0); put_fm0(1'b0, 1'b1);
    put_fm0(1'b1, 1'b0); put_fm0(1'b1, 1'b1); put_fm0(1'b0, 1'b0);
    run_line(1'b0, "R4 fm0 violation");
    // R8 strobe edges, mode bit held at transition coding
    run_strobe(1'b1, 30, "R8 strobe rising");
    run_strobe(1'b0, 30, "R8 strobe falling");
    for (int r = 0; r < 5; r++) begin
      for (int i = 0; i < 40; i++) put_nrz(($urandom % 4) != 0);
      run_line(1'b1, "R3 R5 nrz random");
      for (int i = 0; i < 40; i++) put_fm0(($urandom % 4) != 0, ($urandom % 16) == 0);
      run_line(1'b0, "R2 R4 fm0 random");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule